// File: doc/BRIEF.md
# Oscillator Rate Discriminator Against Line Sync

This block judges whether a free-running local oscillator is running fast or slow compared with a stream of reference events. The reference events are the rising edges of a video line-sync signal. Everything runs in the oscillator's own clock domain. The block counts oscillator cycles across a measurement window that opens on one sync rising edge and closes a fixed number of sync edges later. It then compares the count with a nominal terminal count that is set at build time.

For each closed window the block gives a single one-cycle verdict. A fast pulse means the counter reached its terminal count before the closing edge arrived. A slow pulse means the closing edge arrived first. If both happen in the same cycle, the oscillator is taken as on rate and neither pulse is given. These pulses are meant to feed a loop filter that steers a voltage-controlled oscillator.

The window can cover one line, which is the default and gives the least jitter. It can also cover several lines, which cuts the rounding error of the integer terminal count. If the closing edge does not arrive within twice the terminal count, the block reports lost sync and waits for a fresh edge.

Top module: `line_rate_discriminator`

## Requirements
In this section, D is the number of rising clock edges from the sample at which `sync_in` is first seen high for the opening edge to the sample at which it is first seen high for the closing edge. W is the parameter `WIN_COUNT`, and L is the parameter `LINES`.
- R1: While `rst_n` is low, and after reset until the first verdict, `rate_fast`, `rate_slow` and `sync_lost` are all 0.
- R2: `sync_in` passes through a two-flop synchroniser, and only its low-to-high transitions count. A level held high for many cycles counts as one edge. If `sync_in` is first sampled high at clock edge k, the block acts on it at clock edge k+2.
- R3: If D < W, `rate_slow` is 1 for exactly the cycle that follows clock edge k+2, where k is the sample of the closing edge.
- R4: If W < D <= 2W, `rate_fast` is 1 for exactly the cycle that follows clock edge k+2.
- R5: If D = W, neither `rate_fast` nor `rate_slow` is asserted for that window.
- R6: Every verdict pulse lasts one cycle. `rate_fast` and `rate_slow` are never both 1, and neither is 1 while `sync_lost` is 1.
- R7: A window closes on the L-th rising edge after its opening edge. The rising edges in between produce no verdict.
- R8: The closing edge of a window also opens the next window in the same cycle, so windows run back to back with no gap.
- R9: If the closing edge has not arrived when the count reaches 2W, `sync_lost` is 1 for one cycle, in the cycle that follows clock edge k0+2+2W, where k0 is the sample of the opening edge. The open window is then discarded.
- R10: After reset or after a timeout, the first rising edge only opens a window and produces no verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Local oscillator clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_in | input | 1 | Line-sync reference, asynchronous to `clk_osc` |
| rate_fast | output | 1 | One-cycle pulse: the oscillator is running fast |
| rate_slow | output | 1 | One-cycle pulse: the oscillator is running slow |
| sync_lost | output | 1 | One-cycle pulse: no closing edge within 2W cycles |

## Verification
A cycle counter that is off by one shows at the ports at the end of the next window. In that case a window of exactly W cycles gives a fast or slow pulse when it should give none, and a window of exactly 2W cycles gives a timeout when it should give a verdict. A wrong line count or window state shows within one window: a verdict appears on an intermediate edge, or an opening edge yields a verdict. The bench runs a behavioural reference beside the design and compares all three outputs on every clock, so any such fault shows up in the cycle where the verdict falls due. It places window lengths of W-1, W, W+1, 2W and 2W+1 cycles to hit each of these edges.

// File: rtl/lrd_pkg.sv
package lrd_pkg;

  // Measurement window state
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MEAS = 1'b1
  } meas_state_t;

  // Outcome of a closed window or a lost reference
  typedef enum logic [1:0] {
    VERDICT_NONE = 2'd0,
    VERDICT_FAST = 2'd1,
    VERDICT_SLOW = 2'd2,
    VERDICT_LOST = 2'd3
  } verdict_t;

endpackage

// File: rtl/lrd_reset_sync.sv
module lrd_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/lrd_sync_edge.sv
module lrd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] meta_q;
  logic [STAGES-1:0] meta_d;
  logic              last_q;
  logic              last_d;

  // Synchroniser chain, length picked by the parameter
  generate
    if (STAGES == 1) begin : g_single
      always_comb meta_d = async_in;
    end else begin : g_chain
      always_comb meta_d = {meta_q[STAGES-2:0], async_in};
    end
  endgenerate

  always_comb begin
    last_d = meta_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      last_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      last_q <= last_d;
    end
  end

  assign rise = meta_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/lrd_window_ctrl.sv
module lrd_window_ctrl
  import lrd_pkg::*;
#(
  parameter int WIN_COUNT = 1445,
  parameter int LINES     = 1,
  parameter int CNT_W     = 12,
  parameter int LINE_W    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_rise,
  output logic             win_end,
  output logic             timeout_hit,
  output logic [CNT_W-1:0] cycle_cnt
);

  localparam logic [CNT_W-1:0]  TO_LIMIT  = CNT_W'(2 * WIN_COUNT);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

  meas_state_t       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [LINE_W-1:0] lines_q, lines_d;
  logic              upd_en;
  logic              last_line;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    lines_d     = lines_q;
    win_end     = 1'b0;
    timeout_hit = 1'b0;
    last_line   = (lines_q == LAST_LINE);
    upd_en      = (state_q == ST_MEAS) || sync_rise;
    case (state_q)
      ST_IDLE: begin
        if (sync_rise) begin
          state_d = ST_MEAS;
          cnt_d   = CNT_W'(1);
          lines_d = '0;
        end
      end
      ST_MEAS: begin
        if (sync_rise && last_line) begin
          // close this window and open the next in the same cycle
          win_end = 1'b1;
          cnt_d   = CNT_W'(1);
          lines_d = '0;
        end else if (cnt_q == TO_LIMIT) begin
          timeout_hit = 1'b1;
          state_d     = ST_IDLE;
          cnt_d       = '0;
          lines_d     = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
          if (sync_rise) begin
            lines_d = lines_q + LINE_W'(1);
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
        lines_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lines_q <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lines_q <= lines_d;
    end
  end

  assign cycle_cnt = cnt_q;

endmodule

// File: rtl/lrd_verdict.sv
module lrd_verdict
  import lrd_pkg::*;
#(
  parameter int WIN_COUNT = 1445,
  parameter int CNT_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_end,
  input  logic             timeout_hit,
  input  logic [CNT_W-1:0] cycle_cnt,
  output logic             fast_q,
  output logic             slow_q,
  output logic             lost_q
);

  localparam logic [CNT_W-1:0] NOMINAL = CNT_W'(WIN_COUNT);

  verdict_t verdict_d;
  logic     fast_d, slow_d, lost_d;

  always_comb begin
    verdict_d = VERDICT_NONE;
    if (timeout_hit) begin
      verdict_d = VERDICT_LOST;
    end else if (win_end) begin
      if (cycle_cnt > NOMINAL) begin
        verdict_d = VERDICT_FAST;   // terminal count came first
      end else if (cycle_cnt < NOMINAL) begin
        verdict_d = VERDICT_SLOW;   // reference edge came first
      end
    end
    fast_d = (verdict_d == VERDICT_FAST);
    slow_d = (verdict_d == VERDICT_SLOW);
    lost_d = (verdict_d == VERDICT_LOST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= 1'b0;
      slow_q <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      fast_q <= fast_d;
      slow_q <= slow_d;
      lost_q <= lost_d;
    end
  end

endmodule

// File: rtl/line_rate_discriminator.sv
module line_rate_discriminator #(
  parameter int WIN_COUNT   = 1445,
  parameter int LINES       = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_osc,
  input  logic rst_n,
  input  logic sync_in,
  output logic rate_fast,
  output logic rate_slow,
  output logic sync_lost
);

  localparam int CNT_W  = $clog2(2 * WIN_COUNT + 1);
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1;

  logic             rst_int_n;
  logic             sync_rise;
  logic             win_end;
  logic             timeout_hit;
  logic [CNT_W-1:0] cycle_cnt;

  lrd_reset_sync #(.STAGES(2)) u_rst (
    .clk    (clk_osc),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  lrd_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk_osc),
    .rst_n    (rst_int_n),
    .async_in (sync_in),
    .rise     (sync_rise)
  );

  lrd_window_ctrl #(
    .WIN_COUNT (WIN_COUNT),
    .LINES     (LINES),
    .CNT_W     (CNT_W),
    .LINE_W    (LINE_W)
  ) u_win (
    .clk         (clk_osc),
    .rst_n       (rst_int_n),
    .sync_rise   (sync_rise),
    .win_end     (win_end),
    .timeout_hit (timeout_hit),
    .cycle_cnt   (cycle_cnt)
  );

  lrd_verdict #(
    .WIN_COUNT (WIN_COUNT),
    .CNT_W     (CNT_W)
  ) u_verdict (
    .clk         (clk_osc),
    .rst_n       (rst_int_n),
    .win_end     (win_end),
    .timeout_hit (timeout_hit),
    .cycle_cnt   (cycle_cnt),
    .fast_q      (rate_fast),
    .slow_q      (rate_slow),
    .lost_q      (sync_lost)
  );

endmodule

// File: rtl/lrd_checker.sv
module lrd_checker #(
  parameter int WIN_COUNT = 1445,
  parameter int CNT_W     = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_rise,
  input logic             fast,
  input logic             slow,
  input logic             lost,
  input logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(2 * WIN_COUNT);

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fast && slow));

  assert_fast_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fast |=> !fast);

  assert_slow_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slow |=> !slow);

  assert_lost_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> (!fast && !slow));

  assert_lost_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> !lost);

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT);

  // R7: a verdict only ever follows a detected reference edge
  assert_verdict_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fast || slow) |-> $past(sync_rise));

endmodule

bind line_rate_discriminator lrd_checker #(
  .WIN_COUNT (WIN_COUNT),
  .CNT_W     (CNT_W)
) u_chk (
  .clk       (clk_osc),
  .rst_n     (rst_int_n),
  .sync_rise (sync_rise),
  .fast      (rate_fast),
  .slow      (rate_slow),
  .lost      (sync_lost),
  .cnt       (cycle_cnt)
);

// File: tb/line_rate_discriminator_test.sv
`timescale 1ns/1ps
module line_rate_discriminator_test;

  localparam int W = 16;
  localparam int L = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic sync_in;
  logic rate_fast, rate_slow, sync_lost;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  line_rate_discriminator #(.WIN_COUNT(W), .LINES(L)) uut (
    .clk_osc   (clk),
    .rst_n     (rst_n),
    .sync_in   (sync_in),
    .rate_fast (rate_fast),
    .rate_slow (rate_slow),
    .sync_lost (sync_lost)
  );

  // Behavioural reference: sample history, window age, edges seen
  bit h1, h2, h3;
  bit m_open;
  int m_age;
  int m_edges;
  bit e_fast, e_slow, e_lost;

  always @(posedge clk) begin
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0;
      m_open = 0; m_age = 0; m_edges = 0;
      e_fast = 0; e_slow = 0; e_lost = 0;
    end else begin
      bit r;
      r = h2 && !h3;
      e_fast = 0; e_slow = 0; e_lost = 0;
      if (!m_open) begin
        if (r) begin m_open = 1; m_age = 1; m_edges = 0; end
      end else if (r && (m_edges + 1 == L)) begin
        if (m_age > W) e_fast = 1;
        else if (m_age < W) e_slow = 1;
        m_age = 1; m_edges = 0;
      end else if (m_age == 2 * W) begin
        e_lost = 1; m_open = 0; m_age = 0; m_edges = 0;
      end else begin
        m_age++;
        if (r) m_edges++;
      end
      h3 = h2; h2 = h1; h1 = sync_in;
    end
  end

  // Per-cycle comparison and pulse tallies
  int c_fast = 0, c_slow = 0, c_lost = 0;
  bit cmp_on = 0;

  always @(negedge clk) begin
    if (cmp_on) begin
      n_tests++;
      if (rate_fast !== e_fast) begin
        n_fail++;
        $display("FAIL R4 cycle compare rate_fast actual=%0b expected=%0b @%0t", rate_fast, e_fast, $time);
      end
      if (rate_slow !== e_slow) begin
        n_fail++;
        $display("FAIL R3 cycle compare rate_slow actual=%0b expected=%0b @%0t", rate_slow, e_slow, $time);
      end
      if (sync_lost !== e_lost) begin
        n_fail++;
        $display("FAIL R9 cycle compare sync_lost actual=%0b expected=%0b @%0t", sync_lost, e_lost, $time);
      end
      if (rate_fast && rate_slow) begin
        n_fail++;
        $display("FAIL R6 both verdicts actual=11 expected=not both @%0t", $time);
      end
      c_fast += rate_fast;
      c_slow += rate_slow;
      c_lost += sync_lost;
    end
  end

  task automatic edge_gap(input int gap, input int high = 3);
    sync_in = 1'b1;
    repeat (high) @(negedge clk);
    sync_in = 1'b0;
    repeat (gap - high) @(negedge clk);
  endtask

  task automatic expect_counts(input string tag, input int f, input int s, input int t);
    n_tests++;
    if (c_fast != f || c_slow != s || c_lost != t) begin
      n_fail++;
      $display("FAIL %s pulse counts actual fast=%0d slow=%0d lost=%0d expected fast=%0d slow=%0d lost=%0d",
               tag, c_fast, c_slow, c_lost, f, s, t);
    end
    c_fast = 0; c_slow = 0; c_lost = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    sync_in = 1'b0;
    repeat (5) @(negedge clk);
    // R1: outputs quiet in reset
    n_tests++;
    if ({rate_fast, rate_slow, sync_lost} !== 3'b000) begin
      n_fail++;
      $display("FAIL R1 outputs in reset actual=%b expected=000", {rate_fast, rate_slow, sync_lost});
    end
    rst_n = 1'b1;
    cmp_on = 1'b1;
    repeat (10) @(negedge clk);
    expect_counts("R1 idle after reset", 0, 0, 0);

    // R10: an opening edge alone gives no verdict
    edge_gap(6);
    expect_counts("R10 opening edge", 0, 0, 0);
    // R5 and R7: intermediate edge silent, D = W gives nothing
    edge_gap(10);
    expect_counts("R7 intermediate edge", 0, 0, 0);
    edge_gap(40);
    expect_counts("R5 exact window then R9 timeout", 0, 0, 1);

    // R3 and R8: back-to-back short windows D=15 then D=10
    edge_gap(7); edge_gap(8); edge_gap(5); edge_gap(5); edge_gap(40);
    expect_counts("R3 R8 slow windows", 0, 2, 1);

    // R4: D=17, then D=2W=32 still a verdict
    edge_gap(9); edge_gap(8); edge_gap(20); edge_gap(12); edge_gap(40);
    expect_counts("R4 fast windows incl 2W", 2, 0, 1);

    // R9: D=33 exceeds 2W; closing edge then opens a fresh window (R10)
    edge_gap(20); edge_gap(13); edge_gap(40);
    expect_counts("R9 R10 just over limit", 0, 0, 2);

    // R9: long gap, then a clean window of D=16
    edge_gap(40); edge_gap(8); edge_gap(8); edge_gap(40);
    expect_counts("R9 timeout then locked window", 0, 0, 2);

    // R2: long high levels count once, D=28 fast
    edge_gap(14, 12); edge_gap(14, 12); edge_gap(40);
    expect_counts("R2 long high levels", 1, 0, 1);

    // R3: one short of nominal, D=15
    edge_gap(8); edge_gap(7); edge_gap(40);
    expect_counts("R3 one short", 0, 1, 1);

    cmp_on = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule